// File: doc/BRIEF.md
# Full-Format Indexed Effective Address Unit

This block computes an effective address from a full-format index extension word. The extension word selects the parts of the address. A base register, an index register and a base displacement can each be left out. An optional memory-indirect fetch returns a long-word pointer, and the index is added either before that fetch (pre-indexed) or after it (post-indexed). An outer displacement can then be added to the fetched pointer. Any of these parts may be absent, and the combination still forms a legal mode. With base and displacement suppressed and no indirection, the index register alone becomes the address, which gives plain register indirection through a data register.

The block is started with a one-cycle `start` pulse. The extension word and base value must be valid with that pulse. The block then requests displacement words, one 16-bit word per handshake, through an instruction-word port. It reads the index register through a combinational register-file read port and performs at most one single-beat long-word read on a memory port. It finishes with a one-cycle `done` pulse and the address on `ea_out`. Reserved encodings produce a one-cycle `illegal` pulse instead, and no word or memory request is issued for them.

Top module: `fx_ea_unit`

## Requirements
- R1: The extension word is laid out as follows:
  - bit 15: index register class (0 data, 1 address)
  - bits 14:12: index register number
  - bit 11: index size
  - bits 10:9: scale
  - bit 8: full-format marker, which must be 1 or the encoding is illegal
  - bit 7: base suppress
  - bit 6: index suppress
  - bits 5:4: base displacement size
  - bit 3: unused
  - bits 2:0: indirection select
- R2: When base suppress is 1, the base register contributes zero. When it is 0, `base_reg` is added.
- R3: The index register is read through `idx_sel` = extension bits 15:12. Index size 1 uses all 32 bits, and size 0 uses the low 16 bits sign-extended. Scale codes 00, 01, 10 and 11 multiply the index by 1, 2, 4 and 8. Index suppress 1 removes the index.
- R4: Base displacement size 01 adds zero and consumes no word. Size 10 consumes one word, which is sign-extended. Size 11 consumes two words, high half first. Size 00 is illegal.
- R5: With index suppress 0, indirection select behaves as follows:
  - 000: no memory read; the address is base + base displacement + index.
  - 001 to 011: a long word is read at base + base displacement + index.
  - 101 to 111: a long word is read at base + base displacement, and the index is added to the value read.
  - 100: illegal.
- R6: For memory-indirect modes, the low two bits of indirection select set the outer displacement:
  - 01: zero, no word consumed.
  - 10: one sign-extended word.
  - 11: two words, high first.

  The outer displacement is added to the pointer after the read.
- R7: With index suppress 1, indirection select behaves as follows:
  - 000: no memory read.
  - 001 to 011: a memory read at base + base displacement, with no index.
  - 100 to 111: illegal.
- R8: An illegal encoding pulses `illegal` for one cycle, in the cycle after `start`. For an illegal encoding, `done` does not pulse and `istr_req` and `mem_req` stay low.
- R9: Base displacement words are consumed first, then the memory read is made, then the outer displacement words are consumed. `done` pulses for one cycle with `ea_out` valid. When no word or read is needed, `done` pulses in the cycle after `start`.
- R10: `istr_req` and `mem_req` stay high until acknowledged. `mem_addr` stays stable while a read waits.
- R11: After reset, `done`, `illegal`, `istr_req` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (accepted when idle) |
| ext_word | input | 16 | Full-format extension word, valid with `start` |
| base_reg | input | 32 | Base register value, valid with `start` |
| idx_sel | output | 4 | Index register select {class, number} |
| idx_data | input | 32 | Combinational register-file read data |
| istr_req | output | 1 | Request for the next displacement word |
| istr_ack | input | 1 | Displacement word delivered |
| istr_word | input | 16 | Displacement word |
| mem_req | output | 1 | Long-word read request |
| mem_addr | output | 32 | Read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle reserved-encoding pulse |
| ea_out | output | 32 | Final effective address, valid with `done` |

## Verification
The memory response and the post-index addition land in the same cycle. When the outer displacement is null, completion falls in that cycle too. The bench provokes this by answering reads both at once and after a stall. It judges the result against an independent reference model over all 128 suppress, size and indirection combinations. A new `start` is also driven in the very cycle `done` or `illegal` is high, so each operation begins while the previous one's result is still presented. The bench checks that each address, word count and read count stays correct for both operations.

// File: rtl/fx_ea_unit.sv
module fx_ea_unit #(
  parameter int AW = 32,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] ext_word,
  input  logic [AW-1:0] base_reg,
  output logic [3:0]    idx_sel,
  input  logic [AW-1:0] idx_data,
  output logic          istr_req,
  input  logic          istr_ack,
  input  logic [WW-1:0] istr_word,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic          illegal,
  output logic [AW-1:0] ea_out
);
  localparam int HW = AW - WW;

  typedef enum logic [1:0] {S_IDLE, S_BD, S_MEM, S_OD} st_t;
  st_t st;

  logic [WW-1:0] ext_q, hi_q;
  logic          half_q;
  logic [AW-1:0] acc;

  wire [WW-1:0] w      = (st == S_IDLE) ? ext_word : ext_q;
  wire          bs     = w[7];
  wire          is     = w[6];
  wire [1:0]    bdsz   = w[5:4];
  wire [2:0]    iis    = w[2:0];
  wire          bad    = !w[8] || (bdsz == 2'b00) || (is ? iis[2] : (iis == 3'b100));
  wire          indir  = (iis != 3'b000);
  wire          post   = !is && iis[2];
  wire          pre    = !is && !iis[2];
  wire          bd_none = (bdsz == 2'b01);
  wire          od_none = (iis[1:0] == 2'b01);

  assign idx_sel = w[15:12];
  wire [AW-1:0] ix     = w[11] ? idx_data : {{HW{idx_data[WW-1]}}, idx_data[WW-1:0]};
  wire [AW-1:0] scaled = ix << w[10:9];

  wire [AW-1:0] first_sum = (bs ? '0 : base_reg) + (pre ? scaled : '0);
  wire          long_ph   = (st == S_BD) ? (bdsz == 2'b11) : (iis[1:0] == 2'b11);
  wire [AW-1:0] disp      = long_ph ? {hi_q, istr_word} : {{HW{istr_word[WW-1]}}, istr_word};
  wire [AW-1:0] disp_sum  = acc + disp;
  wire [AW-1:0] ptr_sum   = mem_rdata + (post ? scaled : '0);
  wire          word_in   = istr_req && istr_ack;
  wire          last_word = word_in && !(long_ph && !half_q);

  assign istr_req = (st == S_BD) || (st == S_OD);
  assign mem_req  = (st == S_MEM);
  assign mem_addr = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ext_q   <= '0;
      hi_q    <= '0;
      half_q  <= 1'b0;
      acc     <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
      ea_out  <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (word_in && long_ph && !half_q) begin
        hi_q   <= istr_word;
        half_q <= 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          if (bad) begin
            illegal <= 1'b1;
          end else begin
            ext_q  <= ext_word;
            half_q <= 1'b0;
            acc    <= first_sum;
            if (!bd_none) st <= S_BD;
            else if (indir) st <= S_MEM;
            else begin
              done   <= 1'b1;
              ea_out <= first_sum;
            end
          end
        end
        S_BD: if (last_word) begin
          half_q <= 1'b0;
          acc    <= disp_sum;
          if (indir) st <= S_MEM;
          else begin
            st     <= S_IDLE;
            done   <= 1'b1;
            ea_out <= disp_sum;
          end
        end
        S_MEM: if (mem_ack) begin
          acc <= ptr_sum;
          if (od_none) begin
            st     <= S_IDLE;
            done   <= 1'b1;
            ea_out <= ptr_sum;
          end else begin
            st <= S_OD;
          end
        end
        S_OD: if (last_word) begin
          half_q <= 1'b0;
          st     <= S_IDLE;
          done   <= 1'b1;
          ea_out <= disp_sum;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !istr_req && !mem_req));

  // R5
  mem_only_indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (ext_q[2:0] != 3'b000) && (ext_q[2:0] != 3'b100));

  // R4
  bd_null_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BD) |-> (ext_q[5:4] != 2'b01));

  // R6
  od_null_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OD) |-> (ext_q[1:0] != 2'b01));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R10
  istr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (istr_req && !istr_ack) |=> istr_req);
endmodule

// File: tb/fx_ea_unit_tb.sv
`timescale 1ns/1ps
module fx_ea_unit_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ext_word = '0;
  logic [31:0] base_reg = '0;
  logic [3:0]  idx_sel;
  logic [31:0] idx_data;
  logic        istr_req, istr_ack = 1'b0;
  logic [15:0] istr_word = '0;
  logic        mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        done, illegal;
  logic [31:0] ea_out;

  logic [31:0] rf [16];
  logic [15:0] strm [4];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  assign idx_data = rf[idx_sel];

  fx_ea_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_word(ext_word), .base_reg(base_reg),
    .idx_sel(idx_sel), .idx_data(idx_data), .istr_req(istr_req), .istr_ack(istr_ack),
    .istr_word(istr_word), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .illegal(illegal), .ea_out(ea_out)
  );

  // {ext, expected illegal, expected word count}
  localparam logic [19:0] VEC [8] = '{
    {16'h3990, 1'b0, 3'd0},
    {16'h0165, 1'b1, 3'd0},
    {16'h0161, 1'b0, 3'd1},
    {16'h0061, 1'b1, 3'd0},
    {16'h0141, 1'b1, 3'd0},
    {16'h0124, 1'b1, 3'd0},
    {16'hA737, 1'b0, 3'd4},
    {16'h5D22, 1'b0, 3'd2}
  };

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic is_bad(input logic [15:0] e);
    return !e[8] || e[5:4] == 2'b00 || (e[6] ? e[2] : e[2:0] == 3'b100);
  endfunction

  function automatic logic [31:0] ref_ea(input logic [15:0] e, input logic [31:0] b,
                                         input logic [63:0] ws, output int nw, output int nm);
    logic [31:0] r, ix, isx, bv, bdv, odv, p, m;
    logic [15:0] wd [4];
    int k;
    wd[0] = ws[63:48]; wd[1] = ws[47:32]; wd[2] = ws[31:16]; wd[3] = ws[15:0];
    r   = rf[e[15:12]];
    ix  = e[11] ? r : {{16{r[15]}}, r[15:0]};
    ix  = ix * (32'd1 << e[10:9]);
    isx = e[6] ? 32'd0 : ix;
    bv  = e[7] ? 32'd0 : b;
    k = 0;
    if (e[5:4] == 2'b10) begin bdv = {{16{wd[0][15]}}, wd[0]}; k = 1; end
    else if (e[5:4] == 2'b11) begin bdv = {wd[0], wd[1]}; k = 2; end
    else bdv = 32'd0;
    nm = 0;
    if (e[2:0] == 3'b000) begin
      nw = k;
      return bv + bdv + isx;
    end
    nm = 1;
    p = bv + bdv + (e[2] ? 32'd0 : isx);
    m = memf(p);
    if (e[1:0] == 2'b10) begin odv = {{16{wd[k][15]}}, wd[k]}; k = k + 1; end
    else if (e[1:0] == 2'b11) begin odv = {wd[k], wd[k+1]}; k = k + 2; end
    else odv = 32'd0;
    nw = k;
    return m + (e[2] ? isx : 32'd0) + odv;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  int lat, sp, nm;
  logic dn, il;
  bit stall_bad;

  task automatic run_one(input logic [15:0] e, input logic [31:0] b, input bit slow,
                         input logic [63:0] ws, input string tag);
    logic [31:0] pa;
    bit pst;
    int enw, enm;
    logic [31:0] exp_ea;
    strm[0] = ws[63:48]; strm[1] = ws[47:32]; strm[2] = ws[31:16]; strm[3] = ws[15:0];
    ext_word = e; base_reg = b; start = 1'b1;
    sp = 0; nm = 0; lat = -1; stall_bad = 0; pst = 0; pa = '0; dn = 0; il = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      start = 1'b0; istr_ack = 1'b0; mem_ack = 1'b0;
      if (done || illegal) begin lat = c; dn = done; il = illegal; break; end
      if (pst && (!mem_req || mem_addr !== pa)) stall_bad = 1;
      istr_word = strm[sp < 4 ? sp : 3];
      istr_ack = istr_req && (!slow || c % 2 == 1);
      if (istr_ack) sp++;
      mem_rdata = memf(mem_addr);
      mem_ack = mem_req && (!slow || c % 3 == 2);
      if (mem_ack) nm++;
      pst = mem_req && !mem_ack;
      pa = mem_addr;
    end
    if (lat < 0) begin
      n_chk++; n_bad++;
      $display("FAIL R9 %s: timeout actual none expected done/illegal", tag);
      return;
    end
    exp_ea = ref_ea(e, b, ws, enw, enm);
    if (is_bad(e)) begin
      check({"R8 illegal flag ", tag}, {31'd0, il}, 32'd1);
      check({"R8 no done ", tag}, {31'd0, dn}, 32'd0);
      check({"R8 no requests ", tag}, sp + nm, 32'd0);
      check({"R8 latency ", tag}, lat, 32'd0);
    end else begin
      check({"R2/R3/R5/R6/R7 address ", tag}, ea_out, exp_ea);
      check({"R9 done flag ", tag}, {31'd0, dn}, 32'd1);
      check({"R4/R6 words consumed ", tag}, sp, enw);
      check({"R5/R7 memory reads ", tag}, nm, enm);
      check({"R10 stall address ", tag}, {31'd0, stall_bad}, 32'd0);
    end
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h0100_0000 * i + 32'h0000_8123 + i * 32'h1111;
    rf[3] = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R11
    check("R11 done at reset", {31'd0, done}, 32'd0);
    check("R11 illegal at reset", {31'd0, illegal}, 32'd0);
    check("R11 requests at reset", {30'd0, istr_req, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      int enw, enm;
      logic [31:0] x;
      run_one(VEC[v][19:4], 32'h2000_0100 + v * 32'h40, v[0], 64'h8123_4567_FFF0_0A0B, "vector");
      x = ref_ea(VEC[v][19:4], 32'h2000_0100 + v * 32'h40, 64'h8123_4567_FFF0_0A0B, enw, enm);
      check("R1/R8 vector illegal", {31'd0, il}, {31'd0, VEC[v][3]});
      if (!VEC[v][3]) check("R4/R6 vector words", sp, {29'd0, VEC[v][2:0]});
    end

    // R9 data register indirection finishes next cycle
    run_one(16'h3990, 32'hDEAD_0000, 0, 64'h0, "dreg");
    check("R9 immediate latency", lat, 32'd0);
    check("R3 dreg address", ea_out, 32'h1234_5678);

    // R3 sign-extended word index scaled by 2
    rf[6] = 32'h0000_8001;
    run_one(16'h6390, 32'h0, 0, 64'h0, "sext");
    check("R3 sext scaled index", ea_out, 32'hFFFF_0002);

    // R1 full-format marker cleared
    run_one(16'h3890, 32'h0, 0, 64'h0, "marker");
    check("R1 marker illegal", {31'd0, il}, 32'd1);

    for (int n = 0; n < 128; n++) begin
      logic [15:0] e;
      e[15:12] = 4'((n * 5) % 16);
      e[11]    = n[0] ^ n[4];
      e[10:9]  = n[2:1] ^ n[4:3];
      e[8]     = 1'b1;
      e[7]     = n[6];
      e[6]     = n[5];
      e[5:4]   = n[4:3];
      e[3]     = 1'b0;
      e[2:0]   = n[2:0];
      run_one(e, 32'h1000_0000 + n * 32'h0101_0040, n[1],
              {16'(16'h7F00 ^ n * 16'h0931), 16'(16'h8001 + n * 16'h0123),
               16'(16'hC0DE ^ n), 16'(16'h1357 + n * 16'h0101)}, "sweep");
    end

    @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule